// File: doc/BRIEF.md
# Interleaved Line Read Sequencer

This block fetches a four-word cache line from a memory built out of one-word-wide banks and hands the words back over a one-word bus. Consecutive words of a line live in consecutive banks, so the two low bits of the word address pick the bank. A line read has three phases. One bus cycle carries the address, and every bank starts its access in that same cycle. The sequencer then waits out the common access time, because all the banks are busy in parallel. After that it moves the words out one per bus cycle. With a 15-cycle access the line takes 1 + 15 + 4 = 20 bus cycles from request to last word.

A build parameter selects a comparison mode with a single one-word bank instead. In that mode each word needs its own full access, and the accesses run one after another. The line then takes 1 + 4×15 + 4 = 65 cycles. A request is taken only when the sequencer is idle, which is after the last word of the previous line has gone out. The bank models sit outside the block. Each bank is started by a one-cycle go strobe and presents its word once the access time has elapsed.

Top module: `ilv_line_reader`

## Requirements
- R1: `req_ready` is high exactly when no line is in flight. While it is low, `req_valid` starts no bank access and changes no output.
- R2: In the cycle a request is taken (`req_valid` and `req_ready` both high), interleaved mode drives `bank_go` = 4'b1111, and `bank_addr` equals the line index `req_addr >> 2`, zero-extended.
- R3: In interleaved mode, with a request taken in cycle 0, `rd_valid` is high in cycles 16, 17, 18 and 19 and low in every other cycle of the read (1 address + ACCESS_CYC + 4 transfers).
- R4: Word j of the line (j = 0..3) is the value bank j presents, and the words go out in the order 0, 1, 2, 3.
- R5: `rd_last` is high only together with word 3 of a line.
- R6: The two low bits of `req_addr` are ignored. Every read returns the whole line starting from word 0.
- R7: In single-bank mode only `bank_go[0]` is used. Word j is presented in cycle 16 + 16·j. The bank is started in cycle 0 with word address `{line,2'b00}`, and in the transfer cycle of word j (for j < 3) with word address `{line, j+1}`. The line takes 65 cycles.
- R8: After reset `req_ready` is 1, and `rd_valid`, `rd_last` and `bank_go` are 0.
- R9: A request held high is taken in the cycle right after the last word. Back-to-back reads therefore start every 20 cycles (65 in single-bank mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst | input | 1 | synchronous reset, active high |
| req_valid | input | 1 | line read request |
| req_addr | input | ADDR_W | word address inside the line to read; low bits ignored |
| req_ready | output | 1 | sequencer idle, request taken this cycle if valid |
| bank_go | output | LINE_WORDS | per-bank access start strobe |
| bank_addr | output | ADDR_W | row address for the banks (line index, or word address in single-bank mode) |
| bank_rdata | input | LINE_WORDS*DATA_W | words presented by the banks, bank b at bits [b*DATA_W +: DATA_W] |
| rd_valid | output | 1 | returned word valid |
| rd_data | output | DATA_W | returned word |
| rd_last | output | 1 | final word of the line |

## Verification
The assertions check on every cycle the cycle in which each returned word appears, counted from the accepted request. They also check that the go strobes come only from an accepted request, or in single-bank mode from a transfer cycle. Finally they check that ready is low while words are moving, and that the last flag coincides with the fourth word and is followed by ready. Only the bench scenarios, against a bank model with a real access delay, can show that the data are the right words from the right rows and banks. The same holds for ignoring the low address bits, and for a request held through a busy line being taken exactly one cycle after the last word.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

endpackage

// File: rtl/ilv_wait_timer.sv
module ilv_wait_timer #(
    parameter int CNT_W    = 4,
    parameter int LOAD_VAL = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(LOAD_VAL);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ilv_addr_map.sv
module ilv_addr_map #(
    parameter int ADDR_W      = 30,
    parameter int LINE_WORDS  = 4,
    parameter int INTERLEAVED = 1,
    localparam int SEL_W      = $clog2(LINE_WORDS),
    localparam int LINE_W     = ADDR_W - SEL_W
) (
    input  logic                  issue,
    input  logic [LINE_W-1:0]     line_idx,
    input  logic [SEL_W-1:0]      word_idx,
    output logic [LINE_WORDS-1:0] bank_go,
    output logic [ADDR_W-1:0]     bank_addr
);

    generate
        if (INTERLEAVED != 0) begin : g_banked
            logic unused_word;
            assign unused_word = ^word_idx;
            assign bank_go     = {LINE_WORDS{issue}};
            assign bank_addr   = ADDR_W'(line_idx);
        end else begin : g_single
            assign bank_go   = {{(LINE_WORDS-1){1'b0}}, issue};
            assign bank_addr = {line_idx, word_idx};
        end
    endgenerate

endmodule

// File: rtl/ilv_word_mux.sv
module ilv_word_mux #(
    parameter int DATA_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int INTERLEAVED = 1,
    localparam int SEL_W      = $clog2(LINE_WORDS)
) (
    input  logic [LINE_WORDS*DATA_W-1:0] bank_rdata,
    input  logic [SEL_W-1:0]             sel,
    output logic [DATA_W-1:0]            word
);

    generate
        if (INTERLEAVED != 0) begin : g_banked
            assign word = bank_rdata[sel*DATA_W +: DATA_W];
        end else begin : g_single
            logic unused_rest;
            assign unused_rest = ^{sel, bank_rdata[LINE_WORDS*DATA_W-1:DATA_W]};
            assign word        = bank_rdata[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/ilv_line_reader.sv
module ilv_line_reader #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 30,
    parameter int LINE_WORDS  = 4,
    parameter int ACCESS_CYC  = 15,
    parameter int INTERLEAVED = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         req_ready,
    output logic [LINE_WORDS-1:0]        bank_go,
    output logic [ADDR_W-1:0]            bank_addr,
    input  logic [LINE_WORDS*DATA_W-1:0] bank_rdata,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_last
);
    import ilv_pkg::*;

    localparam int SEL_W  = $clog2(LINE_WORDS);
    localparam int LINE_W = ADDR_W - SEL_W;
    localparam int CNT_W  = (ACCESS_CYC > 1) ? $clog2(ACCESS_CYC) : 1;
    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(LINE_WORDS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [LINE_W-1:0] line;
        logic [SEL_W-1:0]  word;
    } seq_t;

    seq_t st_d, st_q;

    logic              accept;
    logic              issue;
    logic              wait_done;
    logic              at_last;
    logic [LINE_W-1:0] map_line;
    logic [SEL_W-1:0]  map_word;
    logic              unused_low;

    assign unused_low = ^req_addr[SEL_W-1:0];

    always_comb begin
        st_d     = st_q;
        accept   = (st_q.phase == PH_IDLE) && req_valid;
        at_last  = (st_q.phase == PH_XFER) && (st_q.word == LAST_IDX);
        issue    = accept;
        map_line = st_q.line;
        map_word = SEL_W'(st_q.word + 1'b1);

        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_WAIT;
                    st_d.line  = req_addr[ADDR_W-1:SEL_W];
                    st_d.word  = '0;
                    map_line   = req_addr[ADDR_W-1:SEL_W];
                    map_word   = '0;
                end
            end
            PH_WAIT: begin
                if (wait_done) begin
                    st_d.phase = PH_XFER;
                end
            end
            PH_XFER: begin
                if (at_last) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.word = SEL_W'(st_q.word + 1'b1);
                    if (INTERLEAVED == 0) begin
                        st_d.phase = PH_WAIT;
                        issue      = 1'b1;
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.line  <= '0;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ilv_wait_timer #(
        .CNT_W   (CNT_W),
        .LOAD_VAL(ACCESS_CYC - 1)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (issue),
        .expired(wait_done)
    );

    ilv_addr_map #(
        .ADDR_W     (ADDR_W),
        .LINE_WORDS (LINE_WORDS),
        .INTERLEAVED(INTERLEAVED)
    ) u_map (
        .issue    (issue),
        .line_idx (map_line),
        .word_idx (map_word),
        .bank_go  (bank_go),
        .bank_addr(bank_addr)
    );

    ilv_word_mux #(
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .INTERLEAVED(INTERLEAVED)
    ) u_mux (
        .bank_rdata(bank_rdata),
        .sel       (st_q.word),
        .word      (rd_data)
    );

    assign req_ready = (st_q.phase == PH_IDLE);
    assign rd_valid  = (st_q.phase == PH_XFER);
    assign rd_last   = at_last;

endmodule

// File: rtl/ilv_line_reader_chk.sv
module ilv_line_reader_chk #(
    parameter int LINE_WORDS  = 4,
    parameter int ACCESS_CYC  = 15,
    parameter int INTERLEAVED = 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [LINE_WORDS-1:0] bank_go,
    input logic                  rd_valid,
    input logic                  rd_last
);

    localparam int STEP = (INTERLEAVED != 0) ? 1 : ACCESS_CYC + 1;

    logic        accept;
    logic [15:0] since_q;
    logic [15:0] seen_q;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            seen_q  <= '0;
        end else if (accept) begin
            since_q <= 16'd1;
            seen_q  <= '0;
        end else begin
            if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
            if (rd_valid) seen_q <= seen_q + 16'd1;
        end
    end

    // R3 R7
    word_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (since_q == 16'(ACCESS_CYC + 1 + STEP * int'(seen_q))));

    // R2
    accept_issues_chk: assert property (@(posedge clk) disable iff (rst)
        accept |-> bank_go[0]);

    // R1
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !req_ready);

    // R5
    last_on_final_chk: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> (rd_valid && (seen_q == 16'(LINE_WORDS - 1))));

    // R9
    ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> req_ready);

    generate
        if (INTERLEAVED != 0) begin : g_banked
            // R2
            go_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
                (bank_go != '0) |-> (accept && (&bank_go)));
        end else begin : g_single
            // R7
            go_single_bank_chk: assert property (@(posedge clk) disable iff (rst)
                (bank_go != '0) |-> ((accept || (rd_valid && !rd_last)) && $onehot0(bank_go) && bank_go[0]));
        end
    endgenerate

endmodule

bind ilv_line_reader ilv_line_reader_chk #(
    .LINE_WORDS (LINE_WORDS),
    .ACCESS_CYC (ACCESS_CYC),
    .INTERLEAVED(INTERLEAVED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .bank_go  (bank_go),
    .rd_valid (rd_valid),
    .rd_last  (rd_last)
);

// File: tb/ilv_line_reader_test.sv
module ilv_line_reader_test;

    localparam int ACC   = 15;
    localparam int DW    = 32;
    localparam int AW    = 30;
    localparam logic [31:0] POISON = 32'hBAD0_BAD0;

    typedef struct {
        longint      cyc;
        logic [31:0] data;
        bit          last;
    } word_t;

    typedef struct {
        longint      cyc;
        logic [3:0]  mask;
        logic [29:0] addr;
    } go_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic           rq_v  [2];
    logic [AW-1:0]  rq_a  [2];
    logic           rdy   [2];
    logic [3:0]     go    [2];
    logic [AW-1:0]  badr  [2];
    logic [4*DW-1:0] brd  [2];
    logic           vld   [2];
    logic [DW-1:0]  dat   [2];
    logic           lst   [2];

    ilv_line_reader #(.DATA_W(DW), .ADDR_W(AW), .LINE_WORDS(4), .ACCESS_CYC(ACC), .INTERLEAVED(1)) uut (
        .clk(clk), .rst(rst), .req_valid(rq_v[0]), .req_addr(rq_a[0]), .req_ready(rdy[0]),
        .bank_go(go[0]), .bank_addr(badr[0]), .bank_rdata(brd[0]),
        .rd_valid(vld[0]), .rd_data(dat[0]), .rd_last(lst[0]));

    ilv_line_reader #(.DATA_W(DW), .ADDR_W(AW), .LINE_WORDS(4), .ACCESS_CYC(ACC), .INTERLEAVED(0)) uut_single (
        .clk(clk), .rst(rst), .req_valid(rq_v[1]), .req_addr(rq_a[1]), .req_ready(rdy[1]),
        .bank_go(go[1]), .bank_addr(badr[1]), .bank_rdata(brd[1]),
        .rd_valid(vld[1]), .rd_data(dat[1]), .rd_last(lst[1]));

    int     errors = 0;
    int     checks = 0;
    longint cyc    = 0;
    bit     done   = 0;

    longint      busy_until [2];
    word_t       wq  [2][$];
    go_t         gq  [2][$];
    logic [31:0] rx  [2][$];
    longint      acc [2][$];

    int          btmr   [2][4];
    bit          barm   [2][4];
    logic [29:0] badd   [2][4];
    int          btmr_n [2][4];
    bit          barm_n [2][4];
    logic [29:0] badd_n [2][4];

    function automatic logic [31:0] memf(input logic [29:0] a);
        return ({2'b00, a} * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    // bank models: data present once the access time has run out
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            for (int b = 0; b < 4; b++) begin
                if (barm[i][b] && btmr[i][b] == 0)
                    brd[i][b*DW +: DW] = (i == 0) ? memf({badd[i][b][27:0], 2'(b)}) : memf(badd[i][b]);
                else
                    brd[i][b*DW +: DW] = POISON;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < 2; i++) begin
            for (int b = 0; b < 4; b++) begin
                btmr[i][b] <= btmr_n[i][b];
                barm[i][b] <= barm_n[i][b];
                badd[i][b] <= badd_n[i][b];
            end
        end
    end

    task automatic fail(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        errors++;
        $display("FAIL %s inst%0d? %s at cycle %0d: actual=%h expected=%h", tag, 0, what, cyc, act, exp);
    endtask

    task automatic step(input int i);
        int          sz;
        logic [27:0] line;
        bit          exp_rdy;
        go_t         ge;
        word_t       we;
        sz = (i == 0) ? 1 : 16;
        exp_rdy = (cyc > busy_until[i]);
        for (int b = 0; b < 4; b++) begin
            btmr_n[i][b] = btmr[i][b];
            barm_n[i][b] = barm[i][b];
            badd_n[i][b] = badd[i][b];
        end
        // R1: ready only when idle
        checks++;
        if (rdy[i] !== exp_rdy) fail("R1", "req_ready", 64'(rdy[i]), 64'(exp_rdy));
        if (rq_v[i] && exp_rdy) begin
            line = rq_a[i][29:2];
            acc[i].push_back(cyc);
            busy_until[i] = cyc + 16 + 3 * sz;
            for (int j = 0; j < 4; j++)
                wq[i].push_back('{cyc + 16 + j * sz, memf({line, 2'(j)}), (j == 3)});
            if (i == 0) begin
                gq[i].push_back('{cyc, 4'hF, {2'b00, line}});
            end else begin
                gq[i].push_back('{cyc, 4'h1, {line, 2'b00}});
                for (int j = 0; j < 3; j++)
                    gq[i].push_back('{cyc + 16 + 16 * j, 4'h1, {line, 2'(j + 1)}});
            end
        end
        ge = '{cyc, 4'h0, 30'h0};
        if (gq[i].size() != 0 && gq[i][0].cyc == cyc) ge = gq[i].pop_front();
        // R2 (interleaved) / R7 (single): bank start strobes and row address
        checks++;
        if (go[i] !== ge.mask)
            fail((i == 0) ? "R2" : "R7", "bank_go", 64'(go[i]), 64'(ge.mask));
        else if (ge.mask != 0 && badr[i] !== ge.addr)
            fail((i == 0) ? "R2" : "R7", "bank_addr", 64'(badr[i]), 64'(ge.addr));
        we = '{cyc, 32'h0, 1'b0};
        if (wq[i].size() != 0 && wq[i][0].cyc == cyc) begin
            we = wq[i].pop_front();
            // R3/R4/R5 (interleaved) or R7 (single): word, timing, last flag
            checks++;
            if (vld[i] !== 1'b1)
                fail((i == 0) ? "R3" : "R7", "rd_valid", 64'(vld[i]), 64'd1);
            else if (dat[i] !== we.data)
                fail((i == 0) ? "R4" : "R7", "rd_data", 64'(dat[i]), 64'(we.data));
            else if (lst[i] !== we.last)
                fail("R5", "rd_last", 64'(lst[i]), 64'(we.last));
        end else begin
            checks++;
            if (vld[i] !== 1'b0 || lst[i] !== 1'b0)
                fail((i == 0) ? "R3" : "R7", "idle rd_valid/rd_last", 64'({vld[i], lst[i]}), 64'd0);
        end
        if (vld[i] === 1'b1) rx[i].push_back(dat[i]);
        for (int b = 0; b < 4; b++) begin
            if (go[i][b] === 1'b1) begin
                btmr_n[i][b] = ACC;
                barm_n[i][b] = 1'b1;
                badd_n[i][b] = badr[i];
            end else if (btmr[i][b] > 0) begin
                btmr_n[i][b] = btmr[i][b] - 1;
            end
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            step(0);
            step(1);
        end
    end

    task automatic send(input int i, input logic [AW-1:0] a);
        @(negedge clk);
        rq_v[i] = 1'b1;
        rq_a[i] = a;
        while (rdy[i] !== 1'b1) @(negedge clk);
    endtask

    task automatic release_req(input int i);
        @(negedge clk);
        rq_v[i] = 1'b0;
    endtask

    task automatic drain(input int i);
        do begin
            @(negedge clk);
            #2;
        end while (wq[i].size() != 0 || rdy[i] !== 1'b1);
    endtask

    task automatic check_line(input int i, input string tag, input logic [27:0] line);
        for (int j = 0; j < 4; j++) begin
            checks++;
            if (rx[i].size() <= j)
                fail(tag, "missing word", 64'(rx[i].size()), 64'(j + 1));
            else if (rx[i][j] !== memf({line, 2'(j)}))
                fail(tag, "line word", 64'(rx[i][j]), 64'(memf({line, 2'(j)})));
        end
    endtask

    task automatic scenario(input int i);
        longint span;
        span = (i == 0) ? 20 : 65;
        // R4: plain line read, words from banks 0..3 in order
        rx[i].delete();
        send(i, {28'h0000_050, 2'b00});
        release_req(i);
        drain(i);
        check_line(i, "R4", 28'h0000_050);
        // R6: low word-address bits ignored
        rx[i].delete();
        send(i, {28'h0AB_CDE1, 2'b11});
        release_req(i);
        drain(i);
        check_line(i, "R6", 28'h0AB_CDE1);
        // R9 and R1: request held high through busy lines
        acc[i].delete();
        send(i, {28'h0123_456, 2'b01});
        send(i, {28'h0FED_CBA, 2'b10});
        send(i, 30'h3FFF_FFFF);
        release_req(i);
        drain(i);
        checks++;
        if (acc[i].size() != 3) fail("R1", "accept count", 64'(acc[i].size()), 64'd3);
        else begin
            checks++;
            if (acc[i][1] - acc[i][0] != span)
                fail("R9", "back-to-back spacing", 64'(acc[i][1] - acc[i][0]), 64'(span));
            if (acc[i][2] - acc[i][1] != span)
                fail("R9", "back-to-back spacing", 64'(acc[i][2] - acc[i][1]), 64'(span));
        end
        // assorted addresses with idle gaps
        for (int k = 0; k < 5; k++) begin
            send(i, AW'(k * 32'h0123_457 + k));
            release_req(i);
            repeat (k) @(negedge clk);
            drain(i);
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            rq_v[i] = 1'b0;
            rq_a[i] = '0;
            busy_until[i] = -1;
            for (int b = 0; b < 4; b++) begin
                btmr[i][b] = 0; barm[i][b] = 0; badd[i][b] = '0;
                btmr_n[i][b] = 0; barm_n[i][b] = 0; badd_n[i][b] = '0;
            end
        end
        repeat (4) @(negedge clk);
        // R8: reset state
        for (int i = 0; i < 2; i++) begin
            checks++;
            if (rdy[i] !== 1'b1) fail("R8", "req_ready", 64'(rdy[i]), 64'd1);
            checks++;
            if (vld[i] !== 1'b0 || lst[i] !== 1'b0) fail("R8", "rd_valid/rd_last", 64'({vld[i], lst[i]}), 64'd0);
            checks++;
            if (go[i] !== 4'h0) fail("R8", "bank_go", 64'(go[i]), 64'd0);
        end
        rst = 1'b0;
        scenario(0);
        scenario(1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule